// File: doc/BRIEF.md
# Frame store write controller

This block moves one processed image frame into external memory and then tells a downstream accelerator that the frame is ready. A start command gives the destination base address and the total size in bytes. The controller splits the frame into bursts of at most `MAX_BURST` beats. For each burst it issues a one-cycle write request that carries the address and the byte length. It then forwards exactly that many pixels from its input stream to the memory data channel, one beat per accepted pixel.

After the last beat of the last burst has been sent, the controller waits for the memory side to acknowledge that the whole frame is stored. The done pulse to the accelerator is raised in the very cycle the acknowledge arrives. The controller then returns to idle and can accept the next frame. One beat carries one pixel padded to `BEAT_BYTES` bytes. With the default parameters a 128x128 frame (16384 pixels, 65536 bytes) fits in the size field.

Top module: `frame_store_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `start_ready_o` is 1 and `wr_valid_o`, `pix_ready_o`, `wr_data_valid_o` and `write_done_o` are 0.
- R2: A start that is accepted while idle, with a size of S bytes, gives beats = ceil(S / BEAT_BYTES). It leads to a first request whose address equals the start address and whose length is min(beats, MAX_BURST) * BEAT_BYTES bytes.
- R3: Each later request has an address equal to the previous request's address plus the previous request's length. Its length is min(remaining beats, MAX_BURST) * BEAT_BYTES and is never zero. A frame takes exactly ceil(beats / MAX_BURST) requests.
- R4: `wr_valid_o` is high for exactly one cycle per burst. Each accepted pixel shows up on `wr_data_o` with `wr_data_valid_o` high one cycle after acceptance, in input order. Each burst carries exactly length / BEAT_BYTES beats.
- R5: `pix_ready_o` is high only in the data phase of a burst, never at the same time as a request or while idle. A pixel offered while `pix_ready_o` is low is not consumed.
- R6: `write_done_o` is high only in a cycle where `wr_complete_i` is high, after the last beat of the frame has been sent. It lasts exactly one cycle and occurs once per frame.
- R7: `wr_complete_i` received while idle or while bursts are still being sent has no effect: no done pulse, and the frame continues unchanged.
- R8: A start received while a frame is in progress is ignored. `start_ready_o` stays 0 until the done pulse and is 1 in the cycle after it.
- R9: A start with size 0 is ignored. The controller stays idle and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a frame; taken when `start_ready_o` is high |
| start_addr_i | input | ADDR_W | Destination base address in bytes |
| start_size_i | input | SIZE_W | Frame size in bytes |
| start_ready_o | output | 1 | Idle and able to take a start |
| pix_valid_i | input | 1 | Pixel available on `pix_data_i` |
| pix_data_i | input | DATA_W | Pixel value |
| pix_ready_o | output | 1 | Pixel is consumed this cycle if valid |
| wr_addr_o | output | ADDR_W | Burst destination address |
| wr_len_o | output | $clog2(MAX_BURST+1)+$clog2(BEAT_BYTES) | Burst length in bytes |
| wr_valid_o | output | 1 | One-cycle request strobe for address and length |
| wr_data_o | output | DATA_W | Data beat to memory |
| wr_data_valid_o | output | 1 | `wr_data_o` holds a beat |
| wr_complete_i | input | 1 | Memory acknowledge that the frame is stored |
| write_done_o | output | 1 | One-cycle pulse to the accelerator, same cycle as the acknowledge |

## Verification
The bench builds the controller with BEAT_BYTES=4 and MAX_BURST=4, with a 16-bit address and an 8-bit size. With these values every frame from 1 to 12 beats is swept, plus a 63-beat frame. This covers single short bursts, exact multiples of the burst limit, and short final bursts. Each size runs with three pixel gap patterns and varying acknowledge delays. A stray acknowledge and a competing start are injected in the middle of some frames. A size that is not a multiple of the beat width exercises the round-up.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2,
    ST_WAIT = 2'd3
  } fsc_state_e;
endpackage

// File: rtl/fsc_burst_planner.sv
module fsc_burst_planner #(
  parameter int ADDR_W     = 32,
  parameter int BEATS_W    = 16,
  parameter int BURST_W    = 7,
  parameter int MAX_BURST  = 64,
  parameter int BEAT_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  load_addr_i,
  input  logic [BEATS_W-1:0] load_beats_i,
  input  logic               advance_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [BURST_W-1:0] burst_o,
  output logic               last_o
);
  logic [ADDR_W-1:0]  addr_q;
  logic [BEATS_W-1:0] remain_q;
  logic [BURST_W-1:0] burst_q;
  logic [BEATS_W-1:0] remain_next;

  function automatic logic [BURST_W-1:0] clip(input logic [BEATS_W-1:0] n);
    return (n > BEATS_W'(MAX_BURST)) ? BURST_W'(MAX_BURST) : BURST_W'(n);
  endfunction

  assign remain_next = remain_q - BEATS_W'(burst_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      remain_q <= '0;
      burst_q  <= '0;
    end else if (load_i) begin
      addr_q   <= load_addr_i;
      remain_q <= load_beats_i;
      burst_q  <= clip(load_beats_i);
    end else if (advance_i) begin
      addr_q   <= addr_q + (ADDR_W'(burst_q) << BEAT_SHIFT);
      remain_q <= remain_next;
      burst_q  <= clip(remain_next);
    end
  end

  assign addr_o  = addr_q;
  assign burst_o = burst_q;
  assign last_o  = (remain_q == BEATS_W'(burst_q));
endmodule

// File: rtl/fsc_beat_counter.sv
module fsc_beat_counter #(
  parameter int BURST_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear_i,
  input  logic               inc_i,
  input  logic [BURST_W-1:0] burst_i,
  output logic               last_beat_o
);
  logic [BURST_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (inc_i)     cnt_q <= cnt_q + BURST_W'(1);
  end

  assign last_beat_o = ((cnt_q + BURST_W'(1)) == burst_i);
endmodule

// File: rtl/fsc_data_stage.sv
module fsc_data_stage #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  always_ff @(posedge clk) begin
    if (rst) valid_o <= 1'b0;
    else     valid_o <= take_i;
  end

  always_ff @(posedge clk) begin
    if (take_i) data_o <= data_i;
  end
endmodule

// File: rtl/frame_store_ctrl.sv
module frame_store_ctrl
  import fsc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 17,
  parameter int DATA_W     = 24,
  parameter int BEAT_BYTES = 4,
  parameter int MAX_BURST  = 64,
  localparam int BEAT_SHIFT = $clog2(BEAT_BYTES),
  localparam int BURST_W    = $clog2(MAX_BURST + 1),
  localparam int LEN_W      = BURST_W + BEAT_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [SIZE_W-1:0] start_size_i,
  output logic              start_ready_o,
  input  logic              pix_valid_i,
  input  logic [DATA_W-1:0] pix_data_i,
  output logic              pix_ready_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [LEN_W-1:0]  wr_len_o,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_data_valid_o,
  input  logic              wr_complete_i,
  output logic              write_done_o
);
  localparam int BEATS_W = SIZE_W + 1 - BEAT_SHIFT;

  fsc_state_e         state_q, state_d;
  logic [SIZE_W:0]    size_round;
  logic [BEATS_W-1:0] start_beats;
  logic               accept_start, take, burst_end, last_beat, last_burst, advance;
  logic [BURST_W-1:0] burst_beats;

  assign size_round   = {1'b0, start_size_i} + (SIZE_W+1)'(BEAT_BYTES - 1);
  assign start_beats  = size_round[SIZE_W:BEAT_SHIFT];
  assign accept_start = (state_q == ST_IDLE) && start_i && (start_beats != '0);
  assign take         = (state_q == ST_DATA) && pix_valid_i;
  assign burst_end    = take && last_beat;
  assign advance      = burst_end && !last_burst;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_start) state_d = ST_REQ;
      ST_REQ:  state_d = ST_DATA;
      ST_DATA: if (burst_end) state_d = last_burst ? ST_WAIT : ST_REQ;
      ST_WAIT: if (wr_complete_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  fsc_burst_planner #(
    .ADDR_W(ADDR_W), .BEATS_W(BEATS_W), .BURST_W(BURST_W),
    .MAX_BURST(MAX_BURST), .BEAT_SHIFT(BEAT_SHIFT)
  ) u_planner (
    .clk(clk), .rst(rst),
    .load_i(accept_start), .load_addr_i(start_addr_i), .load_beats_i(start_beats),
    .advance_i(advance),
    .addr_o(wr_addr_o), .burst_o(burst_beats), .last_o(last_burst)
  );

  fsc_beat_counter #(.BURST_W(BURST_W)) u_beats (
    .clk(clk), .rst(rst),
    .clear_i(state_q == ST_REQ), .inc_i(take),
    .burst_i(burst_beats), .last_beat_o(last_beat)
  );

  fsc_data_stage #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .take_i(take), .data_i(pix_data_i),
    .data_o(wr_data_o), .valid_o(wr_data_valid_o)
  );

  assign wr_len_o      = LEN_W'(burst_beats) << BEAT_SHIFT;
  assign wr_valid_o    = (state_q == ST_REQ);
  assign pix_ready_o   = (state_q == ST_DATA);
  assign start_ready_o = (state_q == ST_IDLE);
  assign write_done_o  = (state_q == ST_WAIT) && wr_complete_i;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 9,
  parameter int MAX_LEN = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              start_ready_o,
  input logic              pix_ready_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [LEN_W-1:0]  wr_len_o,
  input logic              wr_valid_o,
  input logic              wr_complete_i,
  input logic              write_done_o
);
  logic req_seen_q;

  always_ff @(posedge clk) begin
    if (rst || write_done_o) req_seen_q <= 1'b0;
    else if (wr_valid_o)     req_seen_q <= 1'b1;
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |=> !wr_valid_o); // R4
  AST_REQ_LEN: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> (wr_len_o != '0) && (int'(wr_len_o) <= MAX_LEN)); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pix_ready_o && $past(pix_ready_o)) |-> $stable(wr_addr_o)); // R3
  AST_PIX_PHASE: assert property (@(posedge clk) disable iff (rst)
    pix_ready_o |-> (!start_ready_o && !wr_valid_o)); // R5
  AST_DONE_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    write_done_o |-> wr_complete_i); // R6
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    write_done_o |-> req_seen_q); // R6
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    write_done_o |=> (start_ready_o && !write_done_o)); // R8
endmodule

bind frame_store_ctrl fsc_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LEN(MAX_BURST * BEAT_BYTES)
) u_fsc_chk (
  .clk(clk), .rst(rst), .start_ready_o(start_ready_o), .pix_ready_o(pix_ready_o),
  .wr_addr_o(wr_addr_o), .wr_len_o(wr_len_o), .wr_valid_o(wr_valid_o),
  .wr_complete_i(wr_complete_i), .write_done_o(write_done_o)
);

// File: tb/frame_store_ctrl_bench.sv
module frame_store_ctrl_bench;
  localparam int AW = 16, SW = 8, DW = 8, BB = 4, MB = 4;
  localparam int LW = $clog2(MB + 1) + $clog2(BB);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1, start_i = 1'b0, pix_valid_i = 1'b0, wr_complete_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [SW-1:0] start_size_i = '0;
  logic [DW-1:0] pix_data_i = '0;
  logic          start_ready_o, pix_ready_o, wr_valid_o, wr_data_valid_o, write_done_o;
  logic [AW-1:0] wr_addr_o;
  logic [LW-1:0] wr_len_o;
  logic [DW-1:0] wr_data_o;

  frame_store_ctrl #(.ADDR_W(AW), .SIZE_W(SW), .DATA_W(DW), .BEAT_BYTES(BB), .MAX_BURST(MB))
  u_frame_store_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .start_size_i(start_size_i), .start_ready_o(start_ready_o),
    .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i), .pix_ready_o(pix_ready_o),
    .wr_addr_o(wr_addr_o), .wr_len_o(wr_len_o), .wr_valid_o(wr_valid_o),
    .wr_data_o(wr_data_o), .wr_data_valid_o(wr_data_valid_o),
    .wr_complete_i(wr_complete_i), .write_done_o(write_done_o)
  );

  int checks = 0, fails = 0, seed = 5;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input int addr, input int size, input int stall,
                           input int ack_dly, input bit poke);
    int beats = (size + BB - 1) / BB;
    int exp_addr = addr, left = beats, in_idx = 0, out_idx = 0, reqs = 0, cyc = 0, exp_len;
    @(negedge clk);
    check(start_ready_o === 1'b1, "R8 ready before frame", int'(start_ready_o), 1);
    start_i = 1'b1; start_addr_i = AW'(addr); start_size_i = SW'(size);
    @(negedge clk);
    start_i = 1'b0;
    while (1) begin
      if (wr_valid_o) begin
        exp_len = ((left > MB) ? MB : left) * BB;
        check(int'(wr_addr_o) == exp_addr, (reqs == 0) ? "R2 first address" : "R3 burst address",
              int'(wr_addr_o), exp_addr);
        check(int'(wr_len_o) == exp_len, (reqs == 0) ? "R2 first length" : "R3 burst length",
              int'(wr_len_o), exp_len);
        exp_addr += exp_len; left -= exp_len / BB; reqs++;
      end
      if (wr_data_valid_o) begin
        check(wr_data_o == DW'(seed + out_idx), "R4 data order", int'(wr_data_o), (seed + out_idx) % 256);
        out_idx++;
      end
      if (out_idx >= beats || cyc > 3000) break;
      if (poke && cyc == 3) begin
        start_i = 1'b1; start_addr_i = 16'h1234; start_size_i = 8'd8;
        wr_complete_i = 1'b1;
        #1 check(write_done_o === 1'b0, "R7 stray ack mid-frame", int'(write_done_o), 0);
      end else begin
        start_i = 1'b0; wr_complete_i = 1'b0;
      end
      pix_valid_i = (in_idx < beats) && ((cyc % stall) == 0);
      pix_data_i  = DW'(seed + in_idx);
      if (pix_valid_i && pix_ready_o) in_idx++;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0; wr_complete_i = 1'b0; pix_valid_i = 1'b0;
    check(reqs == (beats + MB - 1) / MB, "R3 request count", reqs, (beats + MB - 1) / MB);
    check(out_idx == beats, "R4 beat count", out_idx, beats);
    check(in_idx == beats, "R5 pixels consumed", in_idx, beats);
    for (int k = 0; k < ack_dly; k++) begin
      #1 check(write_done_o === 1'b0, "R6 no done before ack", int'(write_done_o), 0);
      check(start_ready_o === 1'b0, "R8 busy until done", int'(start_ready_o), 0);
      @(negedge clk);
    end
    wr_complete_i = 1'b1;
    #1 check(write_done_o === 1'b1, "R6 done with ack", int'(write_done_o), 1);
    @(negedge clk);
    wr_complete_i = 1'b0;
    #1 check(write_done_o === 1'b0, "R6 single-cycle done", int'(write_done_o), 0);
    check(start_ready_o === 1'b1, "R8 ready after done", int'(start_ready_o), 1);
    seed += 37;
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    check(start_ready_o === 1'b1, "R1 ready in reset", int'(start_ready_o), 1);
    check(wr_valid_o === 1'b0, "R1 no request in reset", int'(wr_valid_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(start_ready_o === 1'b1, "R1 ready", int'(start_ready_o), 1);
    check(wr_valid_o === 1'b0, "R1 request", int'(wr_valid_o), 0);
    check(pix_ready_o === 1'b0, "R1 pix ready", int'(pix_ready_o), 0);
    check(wr_data_valid_o === 1'b0, "R1 data valid", int'(wr_data_valid_o), 0);
    check(write_done_o === 1'b0, "R1 done", int'(write_done_o), 0);
    // R9: zero size is ignored
    start_i = 1'b1; start_size_i = '0; start_addr_i = 16'h0400;
    @(negedge clk);
    start_i = 1'b0;
    check(start_ready_o === 1'b1, "R9 still idle", int'(start_ready_o), 1);
    check(wr_valid_o === 1'b0, "R9 no request", int'(wr_valid_o), 0);
    @(negedge clk);
    check(wr_valid_o === 1'b0, "R9 no later request", int'(wr_valid_o), 0);
    // R7: ack while idle
    wr_complete_i = 1'b1;
    #1 check(write_done_o === 1'b0, "R7 ack while idle", int'(write_done_o), 0);
    @(negedge clk);
    wr_complete_i = 1'b0;
    for (int b = 1; b <= 12; b++)
      for (int s = 1; s <= 3; s++)
        run_frame(16'h100 * b + 16'h40 * s, b * BB, s, (b + s) % 3, (b >= 4) && (s == 2));
    run_frame(16'h0F00, 63 * BB, 1, 1, 1'b1);
    run_frame(16'h2000, 5, 2, 0, 1'b0); // R2 round-up: 5 bytes -> 2 beats
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired (R6 completion) actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule